// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left in a hung state. A recover command starts a train of SCL pulses on the open-drain clock line. SDA is sampled once in each pulse, just before the high phase ends. As soon as SDA reads high, the pulse train stops and the sequencer drives a stop condition so the bus is left idle. At most a fixed number of pulses (eight by default) is issued. If SDA is still low after the last pulse, the sequencer gives up without a stop condition. A separate stop command drives only the stop condition. This is the remedy when SDA is high but SCL has been left low.

All line activity is paced by a one-cycle tick input, and each tick ends one half-phase of SCL. When the high phase is due to end, the block waits until it reads SCL high, so a target stretching the clock lengthens that phase. The number of pulses issued in the last recovery stays readable. A sticky done flag reports that a recovery has finished, whether it succeeded or not. The higher-level logic decides which command to use and resets the controller on failure. That logic reads SDA directly to tell success from failure.

Top module: `i2c_bus_recover`

## Requirements
- R1: After a synchronous active-low reset both line enables are low (lines released), `busy` is 0, `rec_done` is 0 and `pulse_cnt` is 0.
- R2: A `recover_cmd` accepted while SDA reads low sets `busy` and clears `pulse_cnt`. The block then alternates a low phase (`scl_oe`=1) and a high phase (`scl_oe`=0), each ending on a `tick`. SDA stays released during the pulse train.
- R3: A high phase ends only on a `tick` seen while `scl_in` reads 1. At that instant SDA is sampled and `pulse_cnt` increments by one.
- R4: If SDA reads 1 at the end of a high phase, no further pulse follows. The stop condition follows instead: one tick with `scl_oe`=1 and `sda_oe`=1, then a phase with `scl_oe`=0 and `sda_oe`=1 that ends on a tick with `scl_in` high, then both released. SDA is released only while SCL is released.
- R5: If SDA still reads 0 at the end of pulse number MAX_PULSES (8), the block goes idle with `rec_done`=1 and `pulse_cnt`=8, without driving SDA.
- R6: A `recover_cmd` accepted while SDA reads 1 issues no pulse. It sets `rec_done` on the next cycle with `pulse_cnt`=0.
- R7: A `stop_cmd` accepted when idle drives the stop condition of R4 and returns to idle without setting `rec_done`.
- R8: Commands that arrive while `busy` is 1 are ignored. The count and line activity of the running sequence are unaffected.
- R9: `rec_done` is set when a recovery finishes (success via its stop, or exhaustion). It is cleared when any command is accepted and otherwise holds.
- R10: If `recover_cmd` and `stop_cmd` arrive in the same idle cycle, the recovery runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe that ends an SCL half-phase |
| recover_cmd | input | 1 | Strobe: start SDA recovery pulses |
| stop_cmd | input | 1 | Strobe: drive a stop condition |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A sequence is running |
| rec_done | output | 1 | Sticky recovery-finished flag |
| pulse_cnt | output | CW (4) | SCL pulses issued in the last recovery |

## Verification
The assertions assume that `tick` is a single-cycle strobe. They also assume that the SCL and SDA inputs reflect the block's own pull-downs, so SCL never reads high while the block pulls it low. They do not depend on when a target releases SDA, or for how long it stretches SCL. The bench meets these conditions by building both line inputs as a wired-AND of the block's enables and a modelled target. That target holds SDA low until it has seen a chosen number of rising SCL edges, and it can hold SCL low for a few cycles to stretch the clock. Commands are driven only between clock edges, including some while a sequence is running.

// File: rtl/i2c_rcv_pkg.sv
// Package: shared state encoding for the bus recovery sequencer.
// Assumes: nothing; types only.
package i2c_rcv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // lines released, waiting for a command
        ST_PLOW  = 3'd1,  // recovery pulse, SCL pulled low
        ST_PHIGH = 3'd2,  // recovery pulse, SCL released, SDA sampled at end
        ST_SLOW  = 3'd3,  // stop: SCL low, SDA low
        ST_SHIGH = 3'd4   // stop: SCL released, SDA still low
    } rcv_state_t;

endpackage

// File: rtl/i2c_rcv_counter.sv
// Module: pulse counter for the recovery sequencer.
// Counts the SCL pulses issued in the current recovery and flags the last one.
// Assumes: clear and inc are never both needed to act (clear wins).
module i2c_rcv_counter #(
    parameter int MAX_PULSES = 8,
    localparam int CW = $clog2(MAX_PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_PULSES - 1);
    localparam logic [CW-1:0] MAX_VAL  = CW'(MAX_PULSES);

    // Pulse count register: cleared on a new recovery, stepped per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (inc)    cnt <= cnt + 1'b1;
    end

    // Flag that the pulse now in progress is the final permitted one.
    assign last = (cnt == LAST_VAL);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_VAL)
        else $error("pulse count above limit");

endmodule

// File: rtl/i2c_rcv_fsm.sv
// Module: sequencing control for bus recovery and stop generation.
// Advances one SCL half-phase per tick, stretches high phases until SCL reads
// high, and owns the sticky recovery-done flag.
// Assumes: tick is a one-cycle strobe; scl_in/sda_in are already synchronised.
module i2c_rcv_fsm
    import i2c_rcv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       recover_cmd,
    input  logic       stop_cmd,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       cnt_last,
    output rcv_state_t state,
    output logic       cnt_clear,
    output logic       cnt_inc,
    output logic       rec_done
);
    logic rec_mode;   // the running stop belongs to a recovery
    logic hi_end;     // a high phase ends this cycle

    // High phases end only on a tick with SCL really high (clock stretching).
    assign hi_end    = tick && scl_in;
    // Counter controls: clear when a recovery is accepted, step per pulse end.
    assign cnt_clear = (state == ST_IDLE) && recover_cmd;
    assign cnt_inc   = (state == ST_PHIGH) && hi_end;

    // Main state, mode and done-flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rec_mode <= 1'b0;
            rec_done <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (recover_cmd) begin
                        rec_mode <= 1'b1;
                        if (sda_in) begin
                            rec_done <= 1'b1;
                        end else begin
                            rec_done <= 1'b0;
                            state    <= ST_PLOW;
                        end
                    end else if (stop_cmd) begin
                        rec_mode <= 1'b0;
                        rec_done <= 1'b0;
                        state    <= ST_SLOW;
                    end
                end
                ST_PLOW: begin
                    if (tick) state <= ST_PHIGH;
                end
                ST_PHIGH: begin
                    if (hi_end) begin
                        if (sda_in) begin
                            state <= ST_SLOW;
                        end else if (cnt_last) begin
                            state    <= ST_IDLE;
                            rec_done <= 1'b1;
                        end else begin
                            state <= ST_PLOW;
                        end
                    end
                end
                ST_SLOW: begin
                    if (tick) state <= ST_SHIGH;
                end
                ST_SHIGH: begin
                    if (hi_end) begin
                        state <= ST_IDLE;
                        if (rec_mode) rec_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: an exhausted pulse train ends idle with done raised.
    p_fail_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PHIGH && hi_end && !sda_in && cnt_last)
            |=> (state == ST_IDLE && rec_done))
        else $error("exhausted recovery did not finish");

    // R4: a sampled-high SDA leads straight into the stop condition.
    p_early_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PHIGH && hi_end && sda_in) |=> (state == ST_SLOW))
        else $error("pulse train continued after SDA release");

    // R8: a running sequence never re-enters idle on a command alone.
    p_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLOW && !tick) |=> (state == ST_PLOW))
        else $error("low phase left without tick");

endmodule

// File: rtl/i2c_rcv_drive.sv
// Module: open-drain enable decode for the recovery sequencer.
// Maps the sequencing state to SCL/SDA pull-down enables and busy.
// Assumes: state comes straight from a register, so outputs are glitch-free.
module i2c_rcv_drive
    import i2c_rcv_pkg::*;
(
    input  rcv_state_t state,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy
);
    // Line pull-down selection per phase.
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_PLOW:  scl_oe = 1'b1;
            ST_SLOW:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
            ST_SHIGH: sda_oe = 1'b1;
            default:  ;
        endcase
    end

    // Busy whenever any sequence is running.
    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/i2c_bus_recover.sv
// Module: I2C bus recovery sequencer, top level.
// Issues up to MAX_PULSES SCL pulses to free a stuck SDA, ends with a stop
// condition on success, and can drive a stand-alone stop on request.
// Assumes: scl_in/sda_in are synchronised line levels including this block's
// own pull-downs; tick is a one-cycle strobe per SCL half-phase.
module i2c_bus_recover #(
    parameter int MAX_PULSES = 8,
    localparam int CW = $clog2(MAX_PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          recover_cmd,
    input  logic          stop_cmd,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          busy,
    output logic          rec_done,
    output logic [CW-1:0] pulse_cnt
);
    import i2c_rcv_pkg::*;

    rcv_state_t state;
    logic       cnt_clear;
    logic       cnt_inc;
    logic       cnt_last;

    i2c_rcv_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .recover_cmd (recover_cmd),
        .stop_cmd    (stop_cmd),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .cnt_last    (cnt_last),
        .state       (state),
        .cnt_clear   (cnt_clear),
        .cnt_inc     (cnt_inc),
        .rec_done    (rec_done)
    );

    i2c_rcv_counter #(.MAX_PULSES(MAX_PULSES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .cnt   (pulse_cnt),
        .last  (cnt_last)
    );

    i2c_rcv_drive u_drv (
        .state  (state),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe),
        .busy   (busy)
    );

    // R1/R2: lines are released whenever no sequence is running.
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe))
        else $error("line driven while idle");

    // R2: SDA is never pulled during the recovery pulse train.
    p_pulse_sda_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLOW || state == ST_PHIGH) |-> !sda_oe)
        else $error("SDA driven during pulses");

    // R4: SDA is released only while SCL is released (a stop, never a start).
    p_stop_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe)
        else $error("SDA released with SCL low");

    // R3: each completed high phase adds exactly one to the pulse count.
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PHIGH && tick && scl_in)
            |=> (pulse_cnt == $past(pulse_cnt) + 1'b1))
        else $error("pulse count did not step");

    // R9: the done flag is only ever seen while idle.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> !busy)
        else $error("done flag raised while busy");

endmodule

// File: tb/sim_i2c_bus_recover.sv
// Bench: behavioural reference model compared on every clock, plus directed
// end-of-scenario checks, against a modelled stuck target.
module sim_i2c_bus_recover;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic recover_cmd = 1'b0;
    logic stop_cmd = 1'b0;
    logic sda_hold = 1'b0;
    logic stretch = 1'b0;
    logic scl_in, sda_in;
    logic scl_oe, sda_oe, busy, rec_done;
    logic [3:0] pulse_cnt;

    always #5 clk = ~clk;

    // Wired-AND lines: block pull-downs plus target behaviour.
    assign scl_in = !scl_oe && !stretch;
    assign sda_in = !sda_oe && !sda_hold;

    i2c_bus_recover u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .recover_cmd(recover_cmd), .stop_cmd(stop_cmd),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .rec_done(rec_done), .pulse_cnt(pulse_cnt)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int edges = 0;
    int k_rel = 0;
    int stretch_left = 0;
    logic prev_scl_oe = 1'b0;
    logic saw_sda_oe = 1'b0;
    logic saw_busy = 1'b0;

    // Reference model: phase code 0 idle, 1 pulse-low, 2 pulse-high,
    // 3 stop-low, 4 stop-high.
    int  m_ph = 0;
    int  m_cnt = 0;
    bit  m_done = 0;
    bit  m_rec = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_done = 0; m_rec = 0;
        end else begin
            case (m_ph)
                0: if (recover_cmd) begin
                       m_rec = 1; m_cnt = 0;
                       if (sda_in) m_done = 1;
                       else begin m_done = 0; m_ph = 1; end
                   end else if (stop_cmd) begin
                       m_rec = 0; m_done = 0; m_ph = 3;
                   end
                1: if (tick) m_ph = 2;
                2: if (tick && scl_in) begin
                       m_cnt = m_cnt + 1;
                       if (sda_in) m_ph = 3;
                       else if (m_cnt == 8) begin m_ph = 0; m_done = 1; end
                       else m_ph = 1;
                   end
                3: if (tick) m_ph = 4;
                4: if (tick && scl_in) begin
                       m_ph = 0;
                       if (m_rec) m_done = 1;
                   end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    task automatic compare();
        check("R2 scl_oe", int'(scl_oe), int'(m_ph == 1 || m_ph == 3));
        check("R4 sda_oe", int'(sda_oe), int'(m_ph == 3 || m_ph == 4));
        check("R3 pulse_cnt", int'(pulse_cnt), m_cnt);
        check("R9 rec_done", int'(rec_done), int'(m_done));
        check("R7 busy", int'(busy), int'(m_ph != 0));
    endtask

    // One cycle: compare at the falling edge, then update the target and tick.
    task automatic step();
        @(negedge clk);
        cyc++;
        if (rst_n) compare();
        if (sda_oe) saw_sda_oe = 1'b1;
        if (busy) saw_busy = 1'b1;
        if (prev_scl_oe && !scl_oe) edges++;
        prev_scl_oe = scl_oe;
        sda_hold = (edges < k_rel);
        if (stretch_left > 0 && !scl_oe) begin
            stretch = 1'b1; stretch_left--;
        end else stretch = 1'b0;
        tick = (cyc % 3 == 0);
        recover_cmd = 1'b0;
        stop_cmd = 1'b0;
    endtask

    task automatic setup(input int k);
        edges = 0; k_rel = k; saw_sda_oe = 0; saw_busy = 0;
        sda_hold = (k > 0);
        step();
    endtask

    task automatic wait_idle();
        step();
        for (int i = 0; i < 400 && busy; i++) step();
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(); step(); step();
        // R1: reset state
        check("R1 scl_oe", int'(scl_oe), 0);
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 rec_done", int'(rec_done), 0);
        check("R1 pulse_cnt", int'(pulse_cnt), 0);
        rst_n = 1'b1;
        step();

        // R2/R3/R4: target releases after 3 rising edges
        setup(3);
        recover_cmd = 1'b1;
        wait_idle();
        check("R4 count at release", int'(pulse_cnt), 3);
        check("R4 done after stop", int'(rec_done), 1);
        check("R4 stop driven", int'(saw_sda_oe), 1);

        // R5: target never releases
        setup(100);
        recover_cmd = 1'b1;
        wait_idle();
        check("R5 count at limit", int'(pulse_cnt), 8);
        check("R5 done", int'(rec_done), 1);
        check("R5 no SDA drive", int'(saw_sda_oe), 0);
        check("R5 sda still low", int'(sda_in), 0);

        // R6: SDA already high
        setup(0);
        recover_cmd = 1'b1;
        step();
        check("R6 done", int'(rec_done), 1);
        check("R6 no pulse", int'(pulse_cnt), 0);
        check("R6 not busy", int'(busy), 0);

        // R7/R9: stand-alone stop clears done and does not set it
        setup(0);
        stop_cmd = 1'b1;
        wait_idle();
        check("R7 ran", int'(saw_busy), 1);
        check("R7 drove SDA", int'(saw_sda_oe), 1);
        check("R7 done stays clear", int'(rec_done), 0);

        // R8: commands mid-sequence are ignored
        setup(5);
        recover_cmd = 1'b1;
        step();
        for (int i = 0; i < 200 && pulse_cnt != 2; i++) step();
        recover_cmd = 1'b1; stop_cmd = 1'b1;
        step();
        check("R8 count kept", int'(pulse_cnt), 2);
        wait_idle();
        check("R8 full run count", int'(pulse_cnt), 5);
        check("R8 done", int'(rec_done), 1);

        // R10: both commands in one idle cycle, recovery wins
        setup(1);
        recover_cmd = 1'b1; stop_cmd = 1'b1;
        wait_idle();
        check("R10 count", int'(pulse_cnt), 1);
        check("R10 done", int'(rec_done), 1);

        // R3: clock stretching lengthens high phases
        setup(4);
        stretch_left = 7;
        recover_cmd = 1'b1;
        wait_idle();
        check("R3 stretched count", int'(pulse_cnt), 4);
        check("R3 stretched done", int'(rec_done), 1);

        // R1: reset mid-sequence returns to released lines
        setup(100);
        recover_cmd = 1'b1;
        step(); step(); step(); step();
        rst_n = 1'b0;
        step(); step();
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset scl", int'(scl_oe), 0);
        check("R1 reset cnt", int'(pulse_cnt), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule